// File: doc/BRIEF.md
# Pipeline Hazard Controller

This block is the hazard logic for an in-order five-stage pipeline with fetch, decode, execute, memory and write-back stages. It compares the source register numbers of the instruction in decode with the destination numbers and control flags of the instructions further down the pipe. From these comparisons it drives the operand-forwarding selects for the two ALU inputs, a hold on the program counter and the fetch/decode register, a clear of the control bits that enter the execute stage, a clear of the fetch/decode register when a branch resolved in decode is taken, and a same-cycle write-back bypass for each register-file read port. The datapath, ALU, memories and register storage are not part of it. It only drives their select and enable lines.

The forwarding selects are computed one stage early. While an instruction sits in decode, the block works out which stage will hold each of its operands one cycle later and registers that choice, so the select reaches the execute-stage multiplexers straight from a flip-flop. Branches are predicted not taken, so fetch continues sequentially. A branch that turns out taken clears the single wrong-path instruction. A load followed at once by a consumer of its result costs exactly one bubble.

Top module: `pipe_hazard_ctrl`

## Requirements
- R1: Each ALU operand select is 2 bits: 00 takes the register file, 10 the EX/MEM result, 01 the MEM/WB result. On the clock edge where the decode instruction advances, an operand's select becomes 10 if its source equals `ex_dst` and `ex_wen` is 1.
- R2: Otherwise the select becomes 01 if the source equals `mem_dst` and `mem_wen` is 1, and 00 in all other cases.
- R3: When a source matches both `ex_dst` (with `ex_wen`) and `mem_dst` (with `mem_wen`), the select becomes 10.
- R4: Register 0 never causes forwarding, a load-use hold or a write-back bypass, whatever the flags say.
- R5: `hold_front` and `bubble_ex` are 1 in the same cycle exactly when `ex_load` is 1, `ex_dst` is nonzero and `ex_dst` equals either decode source. Otherwise both are 0.
- R6: A clock edge taken while `hold_front` is 1 sets both operand selects to 00, because a bubble enters execute.
- R7: `flush_front` equals `id_br_taken` and not `hold_front`. A hold wins over a taken branch in the same cycle.
- R8: Each `wb_byp_*` is 1 when `wb_wen` is 1 and `wb_dst` equals the matching decode source, so a read in the same cycle as a write returns the new value.
- R9: A synchronous active-high reset sets both operand selects to 00 on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| id_src_a | input | REG_W | First source register of the decode instruction |
| id_src_b | input | REG_W | Second source register of the decode instruction |
| ex_dst | input | REG_W | Destination register of the execute instruction |
| ex_wen | input | 1 | Execute instruction writes a register |
| ex_load | input | 1 | Execute instruction reads data memory |
| mem_dst | input | REG_W | Destination register of the memory-stage instruction |
| mem_wen | input | 1 | Memory-stage instruction writes a register |
| wb_dst | input | REG_W | Destination register being written back |
| wb_wen | input | 1 | Write-back is active this cycle |
| id_br_taken | input | 1 | Branch in decode resolved as taken |
| fwd_sel_a | output | 2 | Registered select for ALU input A |
| fwd_sel_b | output | 2 | Registered select for ALU input B |
| hold_front | output | 1 | Freeze PC and fetch/decode register |
| bubble_ex | output | 1 | Zero the control bits entering execute, including register and memory writes |
| flush_front | output | 1 | Clear the fetch/decode register |
| wb_byp_a | output | 1 | Read port A takes write-back data |
| wb_byp_b | output | 1 | Read port B takes write-back data |

## Verification
The assertions assume that the inputs are settled and free of X before each rising edge. They also assume that the flags describe the instruction the pipeline holds in that cycle, although no property depends on the sequence of instructions from one cycle to the next. The stimulus meets these assumptions by changing inputs only on the falling edge. With four registers, it walks every combination of source, destination, write, load and branch inputs, including register-0 destinations and double matches. Each combination is compared against the selects expected on the following edge.

// File: rtl/hz_pkg.sv
package hz_pkg;
  // operand source select for the execute-stage multiplexers
  typedef enum logic [1:0] {
    FWD_RF    = 2'b00,
    FWD_MEMWB = 2'b01,
    FWD_EXMEM = 2'b10
  } fwd_sel_e;
endpackage

// File: rtl/hz_fwd_next.sv
// Chooses the operand source one stage early: the producer now in execute
// will sit in EX/MEM next cycle, the one now in memory will sit in MEM/WB.
module hz_fwd_next
  import hz_pkg::*;
#(
  parameter int REG_W = 5
) (
  input  logic [REG_W-1:0] src,
  input  logic [REG_W-1:0] ex_dst,
  input  logic             ex_wen,
  input  logic [REG_W-1:0] mem_dst,
  input  logic             mem_wen,
  output fwd_sel_e         nxt
);
  logic live;
  logic hit_ex;
  logic hit_mem;

  assign live    = (src != '0);
  assign hit_ex  = live && ex_wen  && (ex_dst  == src);
  assign hit_mem = live && mem_wen && (mem_dst == src);

  always_comb begin
    if (hit_ex)       nxt = FWD_EXMEM;  // younger producer wins
    else if (hit_mem) nxt = FWD_MEMWB;
    else              nxt = FWD_RF;
  end
endmodule

// File: rtl/hz_load_use.sv
// Detects a load in execute whose result a decode source needs at once.
module hz_load_use #(
  parameter int REG_W = 5,
  parameter int NSRC  = 2
) (
  input  logic [REG_W-1:0] src [NSRC],
  input  logic [REG_W-1:0] ex_dst,
  input  logic             ex_load,
  output logic             hit
);
  logic [NSRC-1:0] match;

  for (genvar g = 0; g < NSRC; g++) begin : g_src
    assign match[g] = (src[g] == ex_dst);
  end

  assign hit = ex_load && (ex_dst != '0) && (|match);
endmodule

// File: rtl/hz_wb_bypass.sv
// Write-before-read within one cycle: a read port that names the register
// being written back takes the write data instead of the stored value.
module hz_wb_bypass #(
  parameter int REG_W = 5
) (
  input  logic [REG_W-1:0] src,
  input  logic [REG_W-1:0] wb_dst,
  input  logic             wb_wen,
  output logic             byp
);
  assign byp = wb_wen && (wb_dst != '0) && (wb_dst == src);
endmodule

// File: rtl/pipe_hazard_ctrl.sv
module pipe_hazard_ctrl
  import hz_pkg::*;
#(
  parameter int REG_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [REG_W-1:0] id_src_a,
  input  logic [REG_W-1:0] id_src_b,
  input  logic [REG_W-1:0] ex_dst,
  input  logic             ex_wen,
  input  logic             ex_load,
  input  logic [REG_W-1:0] mem_dst,
  input  logic             mem_wen,
  input  logic [REG_W-1:0] wb_dst,
  input  logic             wb_wen,
  input  logic             id_br_taken,
  output logic [1:0]       fwd_sel_a,
  output logic [1:0]       fwd_sel_b,
  output logic             hold_front,
  output logic             bubble_ex,
  output logic             flush_front,
  output logic             wb_byp_a,
  output logic             wb_byp_b
);
  localparam int NSRC = 2;

  logic [REG_W-1:0] src [NSRC];
  fwd_sel_e         sel_nxt [NSRC];
  fwd_sel_e         sel_q   [NSRC];
  logic [NSRC-1:0]  byp_v;
  logic             lu_hit;

  assign src[0] = id_src_a;
  assign src[1] = id_src_b;

  hz_load_use #(.REG_W(REG_W), .NSRC(NSRC)) lu_i (
    .src     (src),
    .ex_dst  (ex_dst),
    .ex_load (ex_load),
    .hit     (lu_hit)
  );

  for (genvar g = 0; g < NSRC; g++) begin : g_port
    hz_fwd_next #(.REG_W(REG_W)) fn_i (
      .src     (src[g]),
      .ex_dst  (ex_dst),
      .ex_wen  (ex_wen),
      .mem_dst (mem_dst),
      .mem_wen (mem_wen),
      .nxt     (sel_nxt[g])
    );

    hz_wb_bypass #(.REG_W(REG_W)) wb_i (
      .src    (src[g]),
      .wb_dst (wb_dst),
      .wb_wen (wb_wen),
      .byp    (byp_v[g])
    );

    // a bubble entering execute carries no operand dependency
    always_ff @(posedge clk) begin
      if (rst || lu_hit) sel_q[g] <= FWD_RF;
      else               sel_q[g] <= sel_nxt[g];
    end
  end

  assign fwd_sel_a   = sel_q[0];
  assign fwd_sel_b   = sel_q[1];
  assign hold_front  = lu_hit;
  assign bubble_ex   = lu_hit;
  // operands of a held branch are not yet valid, so the hold wins
  assign flush_front = id_br_taken && !lu_hit;
  assign wb_byp_a    = byp_v[0];
  assign wb_byp_b    = byp_v[1];
endmodule

// File: rtl/pipe_hazard_ctrl_chk.sv
module pipe_hazard_ctrl_chk #(
  parameter int REG_W = 5
) (
  input logic             clk,
  input logic             rst,
  input logic [REG_W-1:0] id_src_a,
  input logic [REG_W-1:0] id_src_b,
  input logic [REG_W-1:0] ex_dst,
  input logic             ex_wen,
  input logic             ex_load,
  input logic [REG_W-1:0] mem_dst,
  input logic             mem_wen,
  input logic [REG_W-1:0] wb_dst,
  input logic             wb_wen,
  input logic             id_br_taken,
  input logic [1:0]       fwd_sel_a,
  input logic [1:0]       fwd_sel_b,
  input logic             hold_front,
  input logic             bubble_ex,
  input logic             flush_front,
  input logic             wb_byp_a,
  input logic             wb_byp_b
);
  AST_EX_FWD_PRIO: assert property (@(posedge clk) disable iff (rst)
    (!hold_front && id_src_a != '0 && ex_wen && ex_dst == id_src_a) |=> fwd_sel_a == 2'b10); // R3
  AST_MEM_FWD: assert property (@(posedge clk) disable iff (rst)
    (!hold_front && id_src_b != '0 && mem_wen && mem_dst == id_src_b
     && !(ex_wen && ex_dst == id_src_b)) |=> fwd_sel_b == 2'b01); // R2
  AST_BUBBLE_SEL: assert property (@(posedge clk) disable iff (rst)
    hold_front |=> (fwd_sel_a == 2'b00 && fwd_sel_b == 2'b00)); // R6
  AST_LOAD_HOLD: assert property (@(posedge clk) disable iff (rst)
    (ex_load && ex_dst != '0 && ex_dst == id_src_a) |-> (hold_front && bubble_ex)); // R5
  AST_ZERO_NO_HOLD: assert property (@(posedge clk) disable iff (rst)
    (ex_dst == '0) |-> !hold_front); // R4
  AST_ZERO_NO_BYP: assert property (@(posedge clk) disable iff (rst)
    (wb_dst == '0) |-> (!wb_byp_a && !wb_byp_b)); // R4
  AST_HOLD_BEATS_FLUSH: assert property (@(posedge clk) disable iff (rst)
    hold_front |-> !flush_front); // R7
  AST_BRANCH_FLUSH: assert property (@(posedge clk) disable iff (rst)
    (id_br_taken && !hold_front) |-> flush_front); // R7
  AST_WB_BYPASS: assert property (@(posedge clk) disable iff (rst)
    (wb_wen && wb_dst != '0 && wb_dst == id_src_a) |-> wb_byp_a); // R8
endmodule

bind pipe_hazard_ctrl pipe_hazard_ctrl_chk #(.REG_W(REG_W)) chk_i (
  .clk(clk), .rst(rst), .id_src_a(id_src_a), .id_src_b(id_src_b),
  .ex_dst(ex_dst), .ex_wen(ex_wen), .ex_load(ex_load),
  .mem_dst(mem_dst), .mem_wen(mem_wen), .wb_dst(wb_dst), .wb_wen(wb_wen),
  .id_br_taken(id_br_taken), .fwd_sel_a(fwd_sel_a), .fwd_sel_b(fwd_sel_b),
  .hold_front(hold_front), .bubble_ex(bubble_ex), .flush_front(flush_front),
  .wb_byp_a(wb_byp_a), .wb_byp_b(wb_byp_b)
);

// File: tb/pipe_hazard_ctrl_tb_top.sv
module pipe_hazard_ctrl_tb_top;
  localparam int RW = 2;
  localparam int VB = 15;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [RW-1:0] id_src_a, id_src_b, ex_dst, mem_dst, wb_dst;
  logic ex_wen, ex_load, mem_wen, wb_wen, id_br_taken;
  logic [1:0] fwd_sel_a, fwd_sel_b;
  logic hold_front, bubble_ex, flush_front, wb_byp_a, wb_byp_b;

  int checks = 0;
  int failures = 0;

  always #2 clk = ~clk;  // 250 MHz

  pipe_hazard_ctrl #(.REG_W(RW)) dut_i (
    .clk(clk), .rst(rst), .id_src_a(id_src_a), .id_src_b(id_src_b),
    .ex_dst(ex_dst), .ex_wen(ex_wen), .ex_load(ex_load),
    .mem_dst(mem_dst), .mem_wen(mem_wen), .wb_dst(wb_dst), .wb_wen(wb_wen),
    .id_br_taken(id_br_taken), .fwd_sel_a(fwd_sel_a), .fwd_sel_b(fwd_sel_b),
    .hold_front(hold_front), .bubble_ex(bubble_ex), .flush_front(flush_front),
    .wb_byp_a(wb_byp_a), .wb_byp_b(wb_byp_b)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // vector layout: a[1:0] b[3:2] exd[5:4] exw[6] exl[7] md[9:8] mw[10] wd[12:11] ww[13] br[14]
  task automatic drive(input logic [VB-1:0] v);
    id_src_a    = v[1:0];
    id_src_b    = v[3:2];
    ex_dst      = v[5:4];
    ex_wen      = v[6];
    ex_load     = v[7];
    mem_dst     = v[9:8];
    mem_wen     = v[10];
    wb_dst      = v[12:11];
    wb_wen      = v[13];
    id_br_taken = v[14];
  endtask

  function automatic bit exp_hold(input logic [VB-1:0] v);
    return v[7] && (v[5:4] != 0) && (v[5:4] == v[1:0] || v[5:4] == v[3:2]);
  endfunction

  // expected select after the edge that followed vector p, for source s
  task automatic chk_sel(input logic [VB-1:0] p, input logic [RW-1:0] s, input int act);
    bit ex_m, mem_m;
    ex_m  = (s != 0) && p[6]  && (p[5:4] == s);
    mem_m = (s != 0) && p[10] && (p[9:8] == s);
    if (exp_hold(p))         chk("R6 bubble clears select", act, 0);
    else if (ex_m && mem_m)  chk("R3 EX/MEM priority", act, 2);
    else if (ex_m)           chk("R1 EX/MEM forward", act, 2);
    else if (mem_m)          chk("R2 MEM/WB forward", act, 1);
    else if (s == 0)         chk("R4 register 0 not forwarded", act, 0);
    else                     chk("R2 register file", act, 0);
  endtask

  task automatic chk_comb(input logic [VB-1:0] v);
    bit h;
    h = exp_hold(v);
    if (v[7] && v[5:4] == 0) chk("R4 no hold on register 0", int'(hold_front), 0);
    else                     chk("R5 load-use hold", int'(hold_front), int'(h));
    chk("R5 bubble with hold", int'(bubble_ex), int'(h));
    chk("R7 flush", int'(flush_front), int'(v[14] && !h));
    chk("R8 bypass a", int'(wb_byp_a), int'(v[13] && v[12:11] != 0 && v[12:11] == v[1:0]));
    chk("R8 bypass b", int'(wb_byp_b), int'(v[13] && v[12:11] != 0 && v[12:11] == v[3:2]));
  endtask

  initial begin
    logic [VB-1:0] pv;
    // reset with inputs that would otherwise forward from EX/MEM
    drive(15'b000_0000_0101_0101);
    repeat (3) @(negedge clk);
    chk("R9 reset select a", int'(fwd_sel_a), 0);
    chk("R9 reset select b", int'(fwd_sel_b), 0);
    rst = 1'b0;
    pv = '0;
    for (int v = 0; v < (1 << VB); v++) begin
      if (v > 0) begin
        chk_sel(pv, pv[1:0], int'(fwd_sel_a));
        chk_sel(pv, pv[3:2], int'(fwd_sel_b));
      end
      drive(VB'(v));
      #1;
      chk_comb(VB'(v));
      pv = VB'(v);
      @(negedge clk);
    end
    chk_sel(pv, pv[1:0], int'(fwd_sel_a));
    chk_sel(pv, pv[3:2], int'(fwd_sel_b));
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule